// File: doc/BRIEF.md
# Interleaved Multiphase PWM Modulator

This block produces up to four logic-level pulse-width-modulated outputs for a multiphase buck converter from a digital demand word that stands in for the loop error-amplifier output. Every output has its own switching interval of a common programmable length, counted in clock cycles, and the intervals of the active outputs are staggered evenly over the period, so that with N active outputs each interval starts one N-th of a period after the one before.

Inside its interval each output compares a falling ramp against the demand word reduced by that output's own balance correction. The output stays low while the corrected demand is at or below the ramp, goes high once it rises above it, and drops again if the demand falls back to or below the ramp. An output may rise only once per interval; it is re-armed only when its next interval begins. The number of active outputs (2, 3 or 4) comes from a mode input, and a separate enable can turn off the fourth output by itself. Period and output-count changes are taken up only where the first output's interval restarts, so a pulse in progress is never cut short by a new setting.

Top module: `multiphase_pwm`

## Requirements
- R1: With N active outputs and latched period P, the interval of `pwmOut[i]` starts floor(i*P/N) clock cycles after the interval of `pwmOut[0]`; for equal corrected demands the rising edges are spaced by the same amounts.
- R2: `modeSel` value 0 selects 2 active outputs, 1 selects 3, and 2 or 3 select 4; when 4 are selected and `ph4En` is low, only 3 are active (`pwmOut[0]` to `pwmOut[2]`) and they are spaced by thirds.
- R3: At position p (0 to P-1) within its interval an active output is driven high when its corrected demand d exceeds P-1-p; in steady state with 0 < d < P each output gives one pulse of exactly d cycles per interval, ending at the interval end, and successive `pwmOut[0]` rising edges are P cycles apart.
- R4: An output rises at most once per interval: if it falls because the demand dropped, it stays low for the rest of that interval even when the demand rises again, and it rises again in the next interval.
- R5: The corrected demand of output i is `ctrlWord` minus the i-th `CTRL_W`-bit field of `corrIn` (bits i*CTRL_W upward), clamped to zero when the correction exceeds the demand; a demand of zero keeps the output low.
- R6: Outputs beyond the active count are held low.
- R7: A new `periodCfg`, `modeSel` or `ph4En` value is applied only when the interval of `pwmOut[0]` restarts; a pulse in progress ends with the old period. A `periodCfg` below 4 is treated as 4.
- R8: A synchronous reset clears the counters, holds all outputs low, arms every output and loads the configuration; the first interval of `pwmOut[0]` begins in the first cycle after reset, so with demand d its first rise is registered on the (P-d+1)-th rising clock edge at which reset is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| periodCfg | input | PER_W | Switching period in clock cycles (minimum 4) |
| modeSel | input | 2 | Active-output count select: 0 = 2, 1 = 3, 2 or 3 = 4 |
| ph4En | input | 1 | Enable of the fourth output when four are selected |
| ctrlWord | input | CTRL_W | Demand word, unsigned |
| corrIn | input | 4*CTRL_W | Per-output balance corrections, output i in bits i*CTRL_W upward |
| pwmOut | output | 4 | PWM outputs, bit i is output i |

## Verification
The bench builds the block with its default widths, eight bits for both the demand word and the period, which admits periods up to 255 cycles and lets the tests use periods of 40 to 80 cycles alongside one that does not divide by three and one below the minimum of four. At these widths the demand can sit well below, near and above the correction terms, so the clamp to zero, the distinct pulse widths per output and the re-spaced rising edges for two, three and four outputs are all observed. The eight-bit period also keeps every settling wait short enough that the mid-interval period change and the single-rise rule can be checked cycle by cycle.

// File: rtl/mpwm_pkg.sv
package mpwm_pkg;
  localparam int NUM_PH  = 4;
  localparam int PHCNT_W = $clog2(NUM_PH + 1);

  // Control-to-datapath strobes, one bit per output.
  typedef struct packed {
    logic [NUM_PH-1:0] ivlStart;  // first cycle of that output's interval
    logic [NUM_PH-1:0] active;    // output belongs to the active set
  } strobe_t;
endpackage

// File: rtl/mpwm_timebase.sv
module mpwm_timebase
  import mpwm_pkg::*;
#(
  parameter int PER_W = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [PER_W-1:0]              periodCfg,
  input  logic [1:0]                    modeSel,
  input  logic                          ph4En,
  output strobe_t                       strb,
  output logic [NUM_PH-1:0][PER_W-1:0]  rampOut
);
  localparam logic [PER_W-1:0] MIN_PER = PER_W'(NUM_PH);
  localparam int PROD_W = PER_W + 2;

  logic [PER_W-1:0]   cnt;
  logic [PER_W-1:0]   curPer;
  logic [PHCNT_W-1:0] curN;
  logic [PER_W-1:0]   offs [NUM_PH];

  logic [PER_W-1:0]   nextPer;
  logic [PHCNT_W-1:0] nextN;
  logic               wrap;
  logic [NUM_PH-1:0]  startV;
  logic [NUM_PH-1:0]  actV;

  // Offset of output idx inside the period for a given active count.
  function automatic logic [PER_W-1:0] spacing(input logic [PER_W-1:0] per,
                                               input logic [PHCNT_W-1:0] n,
                                               input int idx);
    logic [PROD_W-1:0] prod;
    prod = PROD_W'(per) * PROD_W'(idx);
    case (n)
      PHCNT_W'(2): spacing = PER_W'(prod / 2);
      PHCNT_W'(3): spacing = PER_W'(prod / 3);
      default:     spacing = PER_W'(prod / 4);
    endcase
  endfunction

  always_comb begin
    nextPer = (periodCfg < MIN_PER) ? MIN_PER : periodCfg;
    case (modeSel)
      2'd0:    nextN = PHCNT_W'(2);
      2'd1:    nextN = PHCNT_W'(3);
      default: nextN = ph4En ? PHCNT_W'(4) : PHCNT_W'(3);
    endcase
  end

  assign wrap = (cnt == curPer - 1'b1);

  // Master counter; configuration taken up only at the restart of output 0.
  always_ff @(posedge clk) begin
    if (rst || wrap) begin
      cnt    <= '0;
      curPer <= nextPer;
      curN   <= nextN;
      for (int i = 0; i < NUM_PH; i++) offs[i] <= spacing(nextPer, nextN, i);
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // Per-output position and falling ramp.
  for (genvar g = 0; g < NUM_PH; g++) begin : g_ramp
    logic [PER_W:0] pos;
    always_comb begin
      if (cnt >= offs[g]) pos = {1'b0, cnt} - {1'b0, offs[g]};
      else                pos = {1'b0, cnt} + {1'b0, curPer} - {1'b0, offs[g]};
    end
    assign rampOut[g] = PER_W'({1'b0, curPer} - (PER_W+1)'(1) - pos);
    assign actV[g]    = (PHCNT_W'(g) < curN);
    assign startV[g]  = actV[g] && (cnt == offs[g]);
  end

  assign strb = '{ivlStart: startV, active: actV};

  // R7: counter never reaches the latched period
  p_cnt_below_period_r7: assert property (@(posedge clk) disable iff (rst)
    cnt < curPer);
  // R7: latched settings hold everywhere except at the restart of output 0
  p_cfg_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (cnt != '0) |-> ($stable(curPer) && $stable(curN)));
  // R1: staggered starts never coincide
  p_start_onehot_r1: assert property (@(posedge clk) disable iff (rst)
    $onehot0(startV));
  // R1: output 0 leads, its interval begins at counter restart
  p_phase0_lead_r1: assert property (@(posedge clk) disable iff (rst)
    startV[0] |-> (cnt == '0));
endmodule

// File: rtl/mpwm_slice.sv
module mpwm_slice #(
  parameter int CTRL_W = 8,
  parameter int PER_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CTRL_W-1:0] ctrlWord,
  input  logic [CTRL_W-1:0] corrTerm,
  input  logic [PER_W-1:0]  rampVal,
  input  logic              ivlStart,
  input  logic              active,
  output logic              pwmQ
);
  localparam int CMP_W = (CTRL_W > PER_W) ? CTRL_W : PER_W;

  logic [CTRL_W-1:0] adjRaw;
  logic [CMP_W-1:0]  adjExt;
  logic [CMP_W-1:0]  rampExt;
  logic              above;
  logic              armed;
  logic              armedNow;
  logic              goHigh;

  assign adjRaw   = (ctrlWord >= corrTerm) ? (ctrlWord - corrTerm) : '0;
  assign adjExt   = CMP_W'(adjRaw);
  assign rampExt  = CMP_W'(rampVal);
  assign above    = adjExt > rampExt;
  assign armedNow = armed | ivlStart;
  assign goHigh   = active & armedNow & above;

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      pwmQ  <= 1'b0;
      armed <= 1'b1;
    end else if (goHigh) begin
      pwmQ  <= 1'b1;
      armed <= 1'b0;
    end else begin
      if (!above) pwmQ <= 1'b0;
      armed <= armedNow;
    end
  end

  // Checker state: a rise already seen in the current interval.
  logic pwmPrev;
  logic riseSeen;
  always_ff @(posedge clk) begin
    if (rst) begin
      pwmPrev  <= 1'b0;
      riseSeen <= 1'b0;
    end else begin
      pwmPrev <= pwmQ;
      if (ivlStart || !active)      riseSeen <= 1'b0;
      else if (pwmQ && !pwmPrev)    riseSeen <= 1'b1;
    end
  end

  // R4: a second rise inside one interval is not allowed
  p_single_rise_r4: assert property (@(posedge clk) disable iff (rst)
    (pwmQ && !pwmPrev && !$past(ivlStart)) |-> !riseSeen);
  // R6: an inactive output is low one cycle later
  p_inactive_low_r6: assert property (@(posedge clk) disable iff (rst)
    !active |=> !pwmQ);
  // R5: zero corrected demand forces the output low
  p_zero_demand_low_r5: assert property (@(posedge clk) disable iff (rst)
    (ctrlWord <= corrTerm) |=> !pwmQ);
endmodule

// File: rtl/mpwm_datapath.sv
module mpwm_datapath
  import mpwm_pkg::*;
#(
  parameter int CTRL_W = 8,
  parameter int PER_W  = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [CTRL_W-1:0]             ctrlWord,
  input  logic [NUM_PH*CTRL_W-1:0]      corrIn,
  input  strobe_t                       strb,
  input  logic [NUM_PH-1:0][PER_W-1:0]  rampIn,
  output logic [NUM_PH-1:0]             pwmOut
);
  for (genvar g = 0; g < NUM_PH; g++) begin : g_slice
    mpwm_slice #(
      .CTRL_W (CTRL_W),
      .PER_W  (PER_W)
    ) u_slice (
      .clk      (clk),
      .rst      (rst),
      .ctrlWord (ctrlWord),
      .corrTerm (corrIn[g*CTRL_W +: CTRL_W]),
      .rampVal  (rampIn[g]),
      .ivlStart (strb.ivlStart[g]),
      .active   (strb.active[g]),
      .pwmQ     (pwmOut[g])
    );
  end
endmodule

// File: rtl/multiphase_pwm.sv
module multiphase_pwm
  import mpwm_pkg::*;
#(
  parameter int CTRL_W = 8,
  parameter int PER_W  = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [PER_W-1:0]          periodCfg,
  input  logic [1:0]                modeSel,
  input  logic                      ph4En,
  input  logic [CTRL_W-1:0]         ctrlWord,
  input  logic [NUM_PH*CTRL_W-1:0]  corrIn,
  output logic [NUM_PH-1:0]         pwmOut
);
  strobe_t                      strb;
  logic [NUM_PH-1:0][PER_W-1:0] ramp;

  mpwm_timebase #(
    .PER_W (PER_W)
  ) u_timebase (
    .clk       (clk),
    .rst       (rst),
    .periodCfg (periodCfg),
    .modeSel   (modeSel),
    .ph4En     (ph4En),
    .strb      (strb),
    .rampOut   (ramp)
  );

  mpwm_datapath #(
    .CTRL_W (CTRL_W),
    .PER_W  (PER_W)
  ) u_datapath (
    .clk      (clk),
    .rst      (rst),
    .ctrlWord (ctrlWord),
    .corrIn   (corrIn),
    .strb     (strb),
    .rampIn   (ramp),
    .pwmOut   (pwmOut)
  );
endmodule

// File: tb/multiphase_pwm_bench.sv
module multiphase_pwm_bench;
  localparam int CW = 8;
  localparam int PW = 8;
  localparam int NP = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [PW-1:0] periodCfg = 8'd40;
  logic [1:0]    modeSel = 2'd0;
  logic          ph4En = 1'b1;
  logic [CW-1:0] ctrlWord = 8'd10;
  logic [NP*CW-1:0] corrIn = '0;
  logic [NP-1:0] pwmOut;

  always #2.5 clk = ~clk;  // 200 MHz

  multiphase_pwm #(.CTRL_W(CW), .PER_W(PW)) u_multiphase_pwm (
    .clk(clk), .rst(rst), .periodCfg(periodCfg), .modeSel(modeSel),
    .ph4En(ph4En), .ctrlWord(ctrlWord), .corrIn(corrIn), .pwmOut(pwmOut)
  );

  typedef struct { int width; int gap; } exp_t;
  exp_t expQ [NP][$];

  int nChecks = 0;
  int nFail = 0;
  bit checkEn = 0;
  bit highSeen [NP];
  bit prevP [NP];
  bit riseOk [NP];
  int riseT [NP];
  int gapV [NP];
  int lastRise0 = 0;
  int cyc = 0;

  task automatic check(bit ok, string req, string what, int act, int expv);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  endtask

  // Monitor: measures pulses and pops expected items per output.
  always @(negedge clk) begin
    cyc++;
    for (int i = 0; i < NP; i++) begin
      if (pwmOut[i] && !prevP[i]) begin
        riseT[i]  = cyc;
        riseOk[i] = checkEn;
        gapV[i]   = cyc - lastRise0;
        if (i == 0) lastRise0 = cyc;
        if (checkEn) highSeen[i] = 1;
      end
      if (!pwmOut[i] && prevP[i] && riseOk[i] && checkEn && expQ[i].size() > 0) begin
        exp_t e;
        e = expQ[i].pop_front();
        check(cyc - riseT[i] == e.width, "R3/R5", $sformatf("pulse width out%0d", i),
              cyc - riseT[i], e.width);
        if (e.gap >= 0)
          check(gapV[i] == e.gap, "R1/R2", $sformatf("rise spacing out%0d", i),
                gapV[i], e.gap);
      end
      prevP[i] = pwmOut[i];
    end
  end

  // Driver: applies a configuration, lets it settle, queues expected pulses.
  task automatic runCase(int per, int mode, bit p4, int ctrl,
                         int c0, int c1, int c2, int c3, string tag);
    int peff, n, adj [NP], offs [NP], g;
    int cr [NP];
    cr[0] = c0; cr[1] = c1; cr[2] = c2; cr[3] = c3;
    peff = (per < 4) ? 4 : per;
    n = (mode == 0) ? 2 : (mode == 1) ? 3 : (p4 ? 4 : 3);
    for (int i = 0; i < NP; i++) begin
      adj[i]  = (i < n && ctrl > cr[i]) ? ctrl - cr[i] : 0;
      offs[i] = (i * peff) / n;
    end
    @(negedge clk);
    periodCfg = PW'(per); modeSel = 2'(mode); ph4En = p4;
    ctrlWord = CW'(ctrl);
    corrIn = {CW'(c3), CW'(c2), CW'(c1), CW'(c0)};
    repeat (300) @(negedge clk);
    for (int i = 0; i < NP; i++) begin
      expQ[i].delete();
      highSeen[i] = 0;
      if (adj[i] > 0 && adj[i] < peff) begin
        if (i == 0) g = peff;
        else if (adj[0] == 0) g = -1;
        else g = (((offs[i] + adj[0] - adj[i]) % peff) + peff) % peff;
        for (int k = 0; k < 4; k++) expQ[i].push_back('{width: adj[i], gap: g});
      end
    end
    #1 checkEn = 1;
    repeat (6 * peff) @(negedge clk);
    #1 checkEn = 0;
    for (int i = 0; i < NP; i++) begin
      check(expQ[i].size() == 0, tag, $sformatf("missing pulses out%0d", i),
            expQ[i].size(), 0);
      if (adj[i] == 0)
        check(highSeen[i] == 0, (i >= n) ? "R6" : "R5",
              $sformatf("silent out%0d", i), int'(highSeen[i]), 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int k;
    // R8: reset state and first rise timing (P=40, d=10)
    repeat (4) @(negedge clk);
    check(pwmOut == 4'b0000, "R8", "outputs during reset", int'(pwmOut), 0);
    rst = 0;
    k = 0;
    while (k < 100) begin
      @(posedge clk); k++;
      @(negedge clk);
      if (pwmOut[0]) break;
    end
    check(k == 31, "R8", "edges to first rise", k, 31);

    // R4: drop and restore demand inside one interval (P=40, d=20)
    @(negedge clk); ctrlWord = 8'd20;
    repeat (100) @(negedge clk);
    while (!pwmOut[0]) @(negedge clk);
    k = 0;
    repeat (3) begin @(negedge clk); k++; end
    ctrlWord = 8'd0;
    repeat (2) begin @(negedge clk); k++; end
    check(pwmOut[0] == 1'b0, "R4", "fall on demand drop", int'(pwmOut[0]), 0);
    ctrlWord = 8'd20;
    repeat (3) begin @(negedge clk); k++; end
    check(pwmOut[0] == 1'b0, "R4", "no second rise", int'(pwmOut[0]), 0);
    while (!pwmOut[0] && k < 200) begin @(negedge clk); k++; end
    check(k == 40, "R4", "rise in next interval", k, 40);

    // R7: period change while a pulse is high (P 40 -> 80, d=10)
    ctrlWord = 8'd10;
    repeat (100) @(negedge clk);
    while (!pwmOut[0]) @(negedge clk);
    periodCfg = 8'd80;
    k = 0;
    while (pwmOut[0] && k < 200) begin @(negedge clk); k++; end
    check(k == 10, "R7", "pulse kept old period", k, 10);
    while (!pwmOut[0] && k < 300) begin @(negedge clk); k++; end
    check(k == 80, "R7", "next rise with new period", k, 80);

    // Scoreboard cases
    runCase(40, 0, 1, 10, 0, 0, 0, 0, "R1/R6");          // two outputs
    runCase(60, 1, 1, 30, 0, 5, 12, 0, "R2/R5");         // three, distinct widths
    runCase(37, 1, 1, 9, 0, 0, 0, 0, "R1");              // floor spacing
    runCase(80, 2, 1, 50, 10, 0, 20, 40, "R2/R3");       // four outputs
    runCase(80, 3, 0, 20, 0, 0, 0, 0, "R2/R6");          // fourth disabled
    runCase(64, 2, 1, 16, 0, 30, 0, 0, "R5");            // clamp to zero
    runCase(2, 0, 1, 1, 0, 0, 0, 0, "R7");               // period raised to 4
    summary();
  end
endmodule